// File: doc/BRIEF.md
# Same-Cycle Line Request Coalescer

The block sits between several memory request lanes and a line-granular downstream port. In each cycle it looks at every lane. When no line is in flight, the lowest-numbered valid non-fence lane leads a group. Later lanes that target the same line with a compatible request join that group. Every lane gets a status in the same cycle.

In the cycle after the group forms, one downstream request goes out. It carries the line address, the leader's kind and lock flag, a per-byte access mask covering every member, and the merged write and atomic operand bytes. When the downstream side signals completion with the line contents, the block answers each member once. The answers go out one per cycle in lane order, each with the member's own request ID and, where the kind returns data, the member's bytes.

Fence requests bypass the line path and are acknowledged with their wavefront number in the following cycle. Grouping never spans cycles. While a line is in flight, a request to that line is reported as aliased and a request to any other line as full, and both must be retried.

Top module: `coal_top`

## Requirements
- R1: Out of reset, issueValid, respValid and fenceAckValid are 0, and every lane whose reqValid is 0 reports status NONE. The status codes are NONE=0, ISSUED=1, ALIASED=2 and FULL=3.
- R2: With no line in flight, the lowest valid lane whose kind is not a fence gets ISSUED. The kind codes are LOAD=0, STORE=1, ATOMIC=2 and FENCE=3. In the next cycle, issueValid is 1 for exactly one cycle, with issueLine, issueKind and issueLocked taken from that leader.
- R3: A later lane of the same kind, to the same line, with both lock flags clear, joins the group as ISSUED. issueMask bit k is set for every byte k in [offset, offset+size) of any member. issueData byte k holds the write byte of the highest-numbered STORE or ATOMIC member covering k, and 0 otherwise; LOAD members contribute no data.
- R4: A same-line lane whose kind differs from the leader's is ALIASED.
- R5: A same-line lane is ALIASED when either it or the leader has its lock flag set.
- R6: A same-line lane with its release flag set and a wavefront number different from the leader's is ALIASED.
- R7: Once MAX_GROUP members (default 3) have joined, further otherwise-compatible lanes are ALIASED.
- R8: In the forming cycle, a lane targeting a line other than the leader's is FULL. While a group is in flight, a non-fence lane is ALIASED if it targets the in-flight line and FULL otherwise, and never joins.
- R9: dnDone is accepted from the cycle after issue onward. In the cycle after it, responses start: one per cycle, members in ascending lane order, each with its respId. A LOAD member, and an ATOMIC member with its no-return flag clear, have respHasData=1 and respData byte b equal to dnData byte offset+b for b < size, with the upper bytes 0. Other members have respHasData=0 and respData=0.
- R10: The lowest valid FENCE lane is ISSUED in any cycle, busy or not. In the next cycle, fenceAckValid is 1 with fenceAckWf set to its wavefront number. Other FENCE lanes in that cycle are FULL.
- R11: In the cycle after the last response, respValid is 0 and a new group can form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | LANES | Lane request present |
| reqKind | input | LANES x 2 | Request kind per lane |
| reqLine | input | LANES x LINE_AW | Line address per lane |
| reqOff | input | LANES x OFF_W | Byte offset within the line |
| reqSize | input | LANES x 3 | Byte count, 1 to WORD_BYTES |
| reqData | input | LANES x 8*WORD_BYTES | Write or atomic operand bytes |
| reqId | input | LANES x ID_W | Requester tag |
| reqWf | input | LANES x WF_W | Wavefront number |
| reqLocked | input | LANES | Locked read-modify-write flag |
| reqRelease | input | LANES | Release semantics flag |
| reqNoRet | input | LANES | Atomic without returned value |
| reqStatus | output | LANES x 2 | Same-cycle status per lane |
| issueValid | output | 1 | Downstream request strobe |
| issueLine | output | LINE_AW | Line of the request |
| issueKind | output | 2 | Kind of the leader |
| issueLocked | output | 1 | Leader lock flag |
| issueMask | output | LINE_BYTES | Bytes touched by the group |
| issueData | output | 8*LINE_BYTES | Merged write bytes |
| dnDone | input | 1 | Downstream completion |
| dnData | input | 8*LINE_BYTES | Line contents, pre-operation for atomics |
| respValid | output | 1 | Member response strobe |
| respId | output | ID_W | Tag of the answered member |
| respData | output | 8*WORD_BYTES | Returned bytes |
| respHasData | output | 1 | respData carries a value |
| fenceAckValid | output | 1 | Fence acknowledged |
| fenceAckWf | output | WF_W | Wavefront of the acknowledged fence |

## Verification
A fence acknowledgement and the line path can fall in the same cycle. The bench provokes this in two ways: it places fences among lanes that also form a group, and it sends fences during the issue, wait and response phases of an in-flight line. The fence must get its acknowledgement one cycle later with the right wavefront, and the group's status, issue and response outputs must not be disturbed. Group formation and the busy rejection can also collide, since requests for the in-flight line keep arriving while it waits. The bench judges each lane's status against a model that knows which line is outstanding.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {K_LOAD = 2'd0, K_STORE = 2'd1, K_ATOMIC = 2'd2, K_FENCE = 2'd3} kind_e;
  typedef enum logic [1:0] {S_NONE = 2'd0, S_ISSUED = 2'd1, S_ALIASED = 2'd2, S_FULL = 2'd3} status_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_RESP} phase_e;
  typedef struct packed {
    logic capture;
    logic fill;
    logic respFire;
  } strobe_t;
endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl import coal_pkg::*; #(
  parameter int LANES     = 4,
  parameter int LINE_AW   = 8,
  parameter int WF_W      = 3,
  parameter int MAX_GROUP = 3,
  localparam int LIDX_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LANES-1:0]                  reqValid,
  input  logic [LANES-1:0][1:0]             reqKind,
  input  logic [LANES-1:0][LINE_AW-1:0]     reqLine,
  input  logic [LANES-1:0][WF_W-1:0]        reqWf,
  input  logic [LANES-1:0]                  reqLocked,
  input  logic [LANES-1:0]                  reqRelease,
  input  logic [LINE_AW-1:0]                curLine,
  input  logic                              dnDone,
  output logic [LANES-1:0][1:0]             reqStatus,
  output strobe_t                           strb,
  output logic [LANES-1:0]                  joinMask,
  output logic [LIDX_W-1:0]                 leaderIdx,
  output logic [LIDX_W-1:0]                 respSel,
  output logic                              issueValid,
  output logic                              respValid,
  output logic                              fenceAckValid,
  output logic [WF_W-1:0]                   fenceAckWf
);
  phase_e            phase;
  logic [LANES-1:0]  pending;
  logic              leaderFound, fenceFound, busy;
  logic [LIDX_W-1:0] fenceIdx;
  logic [CNT_W-1:0]  cnt;
  logic [LANES-1:0]  selOneHot;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    leaderFound = 1'b0;
    leaderIdx   = '0;
    fenceFound  = 1'b0;
    fenceIdx    = '0;
    for (int j = 0; j < LANES; j++) begin
      if (reqValid[j] && reqKind[j] == K_FENCE && !fenceFound) begin
        fenceFound = 1'b1;
        fenceIdx   = LIDX_W'(j);
      end
      if (reqValid[j] && reqKind[j] != K_FENCE && !leaderFound) begin
        leaderFound = 1'b1;
        leaderIdx   = LIDX_W'(j);
      end
    end
  end

  always_comb begin
    cnt      = '0;
    joinMask = '0;
    for (int j = 0; j < LANES; j++) begin
      if (!reqValid[j]) begin
        reqStatus[j] = S_NONE;
      end else if (reqKind[j] == K_FENCE) begin
        reqStatus[j] = (LIDX_W'(j) == fenceIdx) ? S_ISSUED : S_FULL;
      end else if (busy) begin
        reqStatus[j] = (reqLine[j] == curLine) ? S_ALIASED : S_FULL;
      end else if (LIDX_W'(j) == leaderIdx) begin
        reqStatus[j] = S_ISSUED;
        joinMask[j]  = 1'b1;
        cnt          = cnt + CNT_W'(1);
      end else if (reqLine[j] != reqLine[leaderIdx]) begin
        reqStatus[j] = S_FULL;
      end else if (reqKind[j] != reqKind[leaderIdx] || reqLocked[j] || reqLocked[leaderIdx] ||
                   (reqRelease[j] && reqWf[j] != reqWf[leaderIdx]) ||
                   cnt >= CNT_W'(MAX_GROUP)) begin
        reqStatus[j] = S_ALIASED;
      end else begin
        reqStatus[j] = S_ISSUED;
        joinMask[j]  = 1'b1;
        cnt          = cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    respSel = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (pending[j]) respSel = LIDX_W'(j);
    end
    selOneHot = '0;
    selOneHot[respSel] = 1'b1;
  end

  assign strb.capture  = !busy && leaderFound;
  assign strb.fill     = (phase == PH_WAIT) && dnDone;
  assign strb.respFire = (phase == PH_RESP);
  assign issueValid    = (phase == PH_ISSUE);
  assign respValid     = (phase == PH_RESP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase         <= PH_IDLE;
      pending       <= '0;
      fenceAckValid <= 1'b0;
      fenceAckWf    <= '0;
    end else begin
      fenceAckValid <= fenceFound;
      fenceAckWf    <= reqWf[fenceIdx];
      case (phase)
        PH_IDLE: if (strb.capture) begin
          phase   <= PH_ISSUE;
          pending <= joinMask;
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT:  if (dnDone) phase <= PH_RESP;
        PH_RESP: begin
          pending <= pending & ~selOneHot;
          if ((pending & ~selOneHot) == '0) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);
  // R9
  resp_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respValid) |-> $past(dnDone));
  // R9
  resp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(respValid)) |-> (respSel > $past(respSel)));
  // R7
  group_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> ($countones(joinMask) <= MAX_GROUP));
  // R10
  fence_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    fenceAckValid |-> $past(fenceFound));
endmodule

// File: rtl/coal_data.sv
module coal_data import coal_pkg::*; #(
  parameter int LANES      = 4,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int LINE_AW    = 8,
  parameter int ID_W       = 6,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LIDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strb,
  input  logic [LANES-1:0]                    joinMask,
  input  logic [LIDX_W-1:0]                   leaderIdx,
  input  logic [LIDX_W-1:0]                   respSel,
  input  logic                                issueValid,
  input  logic [LANES-1:0][1:0]               reqKind,
  input  logic [LANES-1:0][LINE_AW-1:0]       reqLine,
  input  logic [LANES-1:0][OFF_W-1:0]         reqOff,
  input  logic [LANES-1:0][2:0]               reqSize,
  input  logic [LANES-1:0][8*WORD_BYTES-1:0]  reqData,
  input  logic [LANES-1:0][ID_W-1:0]          reqId,
  input  logic [LANES-1:0]                    reqLocked,
  input  logic [LANES-1:0]                    reqNoRet,
  input  logic [8*LINE_BYTES-1:0]             dnData,
  output logic [LINE_AW-1:0]                  curLine,
  output logic [1:0]                          issueKind,
  output logic                                issueLocked,
  output logic [LINE_BYTES-1:0]               issueMask,
  output logic [8*LINE_BYTES-1:0]             issueData,
  output logic [ID_W-1:0]                     respId,
  output logic [8*WORD_BYTES-1:0]             respData,
  output logic                                respHasData
);
  logic [LANES-1:0]                   entValid;
  logic [LANES-1:0][1:0]              entKind;
  logic [LANES-1:0][OFF_W-1:0]        entOff;
  logic [LANES-1:0][2:0]              entSize;
  logic [LANES-1:0][8*WORD_BYTES-1:0] entData;
  logic [LANES-1:0][ID_W-1:0]         entId;
  logic [LANES-1:0]                   entNoRet;
  logic [8*LINE_BYTES-1:0]            lineBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid    <= '0;
      curLine     <= '0;
      issueKind   <= '0;
      issueLocked <= 1'b0;
      lineBuf     <= '0;
    end else begin
      if (strb.capture) begin
        entValid    <= joinMask;
        curLine     <= reqLine[leaderIdx];
        issueKind   <= reqKind[leaderIdx];
        issueLocked <= reqLocked[leaderIdx];
      end
      if (strb.fill) lineBuf <= dnData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entKind[g]  <= '0;
        entOff[g]   <= '0;
        entSize[g]  <= '0;
        entData[g]  <= '0;
        entId[g]    <= '0;
        entNoRet[g] <= 1'b0;
      end else if (strb.capture && joinMask[g]) begin
        entKind[g]  <= reqKind[g];
        entOff[g]   <= reqOff[g];
        entSize[g]  <= reqSize[g];
        entData[g]  <= reqData[g];
        entId[g]    <= reqId[g];
        entNoRet[g] <= reqNoRet[g];
      end
    end
  end

  always_comb begin
    issueMask = '0;
    issueData = '0;
    for (int j = 0; j < LANES; j++) begin
      if (entValid[j]) begin
        for (int b = 0; b < WORD_BYTES; b++) begin
          if (b < int'(entSize[j]) && int'(entOff[j]) + b < LINE_BYTES) begin
            issueMask[int'(entOff[j]) + b] = 1'b1;
            if (entKind[j] != K_LOAD)
              issueData[(int'(entOff[j]) + b)*8 +: 8] = entData[j][b*8 +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    respId      = entId[respSel];
    respHasData = strb.respFire &&
                  (entKind[respSel] == K_LOAD || (entKind[respSel] == K_ATOMIC && !entNoRet[respSel]));
    respData    = '0;
    if (respHasData) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (b < int'(entSize[respSel]) && int'(entOff[respSel]) + b < LINE_BYTES)
          respData[b*8 +: 8] = lineBuf[(int'(entOff[respSel]) + b)*8 +: 8];
      end
    end
  end

  // R3
  issue_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueMask != '0));
endmodule

// File: rtl/coal_top.sv
module coal_top import coal_pkg::*; #(
  parameter int LANES      = 4,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  parameter int LINE_AW    = 8,
  parameter int ID_W       = 6,
  parameter int WF_W       = 3,
  parameter int MAX_GROUP  = 3,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [LANES-1:0]                    reqValid,
  input  logic [LANES-1:0][1:0]               reqKind,
  input  logic [LANES-1:0][LINE_AW-1:0]       reqLine,
  input  logic [LANES-1:0][OFF_W-1:0]         reqOff,
  input  logic [LANES-1:0][2:0]               reqSize,
  input  logic [LANES-1:0][8*WORD_BYTES-1:0]  reqData,
  input  logic [LANES-1:0][ID_W-1:0]          reqId,
  input  logic [LANES-1:0][WF_W-1:0]          reqWf,
  input  logic [LANES-1:0]                    reqLocked,
  input  logic [LANES-1:0]                    reqRelease,
  input  logic [LANES-1:0]                    reqNoRet,
  output logic [LANES-1:0][1:0]               reqStatus,
  output logic                                issueValid,
  output logic [LINE_AW-1:0]                  issueLine,
  output logic [1:0]                          issueKind,
  output logic                                issueLocked,
  output logic [LINE_BYTES-1:0]               issueMask,
  output logic [8*LINE_BYTES-1:0]             issueData,
  input  logic                                dnDone,
  input  logic [8*LINE_BYTES-1:0]             dnData,
  output logic                                respValid,
  output logic [ID_W-1:0]                     respId,
  output logic [8*WORD_BYTES-1:0]             respData,
  output logic                                respHasData,
  output logic                                fenceAckValid,
  output logic [WF_W-1:0]                     fenceAckWf
);
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  strobe_t           strb;
  logic [LANES-1:0]  joinMask;
  logic [LIDX_W-1:0] leaderIdx, respSel;
  logic [LINE_AW-1:0] curLine;

  assign issueLine = curLine;

  coal_ctrl #(.LANES(LANES), .LINE_AW(LINE_AW), .WF_W(WF_W), .MAX_GROUP(MAX_GROUP)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqLine(reqLine),
    .reqWf(reqWf), .reqLocked(reqLocked), .reqRelease(reqRelease), .curLine(curLine),
    .dnDone(dnDone), .reqStatus(reqStatus), .strb(strb), .joinMask(joinMask),
    .leaderIdx(leaderIdx), .respSel(respSel), .issueValid(issueValid), .respValid(respValid),
    .fenceAckValid(fenceAckValid), .fenceAckWf(fenceAckWf)
  );

  coal_data #(.LANES(LANES), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
              .LINE_AW(LINE_AW), .ID_W(ID_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .joinMask(joinMask), .leaderIdx(leaderIdx),
    .respSel(respSel), .issueValid(issueValid), .reqKind(reqKind), .reqLine(reqLine),
    .reqOff(reqOff), .reqSize(reqSize), .reqData(reqData), .reqId(reqId),
    .reqLocked(reqLocked), .reqNoRet(reqNoRet), .dnData(dnData), .curLine(curLine),
    .issueKind(issueKind), .issueLocked(issueLocked), .issueMask(issueMask),
    .issueData(issueData), .respId(respId), .respData(respData), .respHasData(respHasData)
  );
endmodule

// File: tb/test_coal_top.sv
`timescale 1ns/1ps
module test_coal_top;
  localparam int N = 4;
  localparam int MAXG = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]        reqValid;
  logic [N-1:0][1:0]   reqKind;
  logic [N-1:0][7:0]   reqLine;
  logic [N-1:0][3:0]   reqOff;
  logic [N-1:0][2:0]   reqSize;
  logic [N-1:0][31:0]  reqData;
  logic [N-1:0][5:0]   reqId;
  logic [N-1:0][2:0]   reqWf;
  logic [N-1:0]        reqLocked, reqRelease, reqNoRet;
  logic [N-1:0][1:0]   reqStatus;
  logic                issueValid, issueLocked;
  logic [7:0]          issueLine;
  logic [1:0]          issueKind;
  logic [15:0]         issueMask;
  logic [127:0]        issueData;
  logic                dnDone;
  logic [127:0]        dnData;
  logic                respValid, respHasData, fenceAckValid;
  logic [5:0]          respId;
  logic [31:0]         respData;
  logic [2:0]          fenceAckWf;

  coal_top i_coal_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqLine(reqLine),
    .reqOff(reqOff), .reqSize(reqSize), .reqData(reqData), .reqId(reqId), .reqWf(reqWf),
    .reqLocked(reqLocked), .reqRelease(reqRelease), .reqNoRet(reqNoRet),
    .reqStatus(reqStatus), .issueValid(issueValid), .issueLine(issueLine),
    .issueKind(issueKind), .issueLocked(issueLocked), .issueMask(issueMask),
    .issueData(issueData), .dnDone(dnDone), .dnData(dnData), .respValid(respValid),
    .respId(respId), .respData(respData), .respHasData(respHasData),
    .fenceAckValid(fenceAckValid), .fenceAckWf(fenceAckWf)
  );

  int checks = 0;
  int fails = 0;

  bit       vA[N];
  bit [1:0] kA[N];
  bit [7:0] lA[N];
  bit [3:0] oA[N];
  bit [2:0] sA[N];
  bit [31:0] dA[N];
  bit [5:0] iA[N];
  bit [2:0] wA[N];
  bit       lkA[N], rlA[N], nrA[N];

  bit [1:0] expSt[N];
  string    expWhy[N];
  bit       expJoin[N];
  bit       expFence;
  bit [2:0] expFenceWf;
  int       leadM;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic applyIn();
    for (int j = 0; j < N; j++) begin
      reqValid[j] = vA[j]; reqKind[j] = kA[j]; reqLine[j] = lA[j]; reqOff[j] = oA[j];
      reqSize[j] = sA[j]; reqData[j] = dA[j]; reqId[j] = iA[j]; reqWf[j] = wA[j];
      reqLocked[j] = lkA[j]; reqRelease[j] = rlA[j]; reqNoRet[j] = nrA[j];
    end
  endtask

  task automatic clearArr();
    for (int j = 0; j < N; j++) begin
      vA[j] = 0; kA[j] = 0; lA[j] = 0; oA[j] = 0; sA[j] = 1; dA[j] = 0; iA[j] = 0;
      wA[j] = 0; lkA[j] = 0; rlA[j] = 0; nrA[j] = 0;
    end
  endtask

  task automatic randLane(input int j, input bit [7:0] la, input bit [7:0] lb);
    int r = $urandom % 10;
    int sz;
    vA[j] = ($urandom % 4) != 0;
    kA[j] = (r < 4) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
    lA[j] = ($urandom % 4 == 0) ? lb : la;
    sz = (1 << ($urandom % 3));
    sA[j] = 3'(sz);
    oA[j] = 4'(($urandom % (16 / sz)) * sz);
    dA[j] = $urandom; iA[j] = 6'($urandom); wA[j] = 3'($urandom % 4);
    lkA[j] = ($urandom % 8) == 0; rlA[j] = ($urandom % 4) == 0; nrA[j] = $urandom % 2;
  endtask

  // Status model taken from R2..R8 and R10
  task automatic model(input bit busyM, input bit [7:0] busyLine);
    int cnt = 0;
    bit fseen = 0;
    leadM = -1;
    expFence = 0; expFenceWf = 0;
    for (int j = 0; j < N; j++) if (vA[j] && kA[j] != 3 && leadM < 0) leadM = j;
    for (int j = 0; j < N; j++) begin
      expJoin[j] = 0;
      if (!vA[j]) begin expSt[j] = 0; expWhy[j] = "R1"; end
      else if (kA[j] == 3) begin
        if (!fseen) begin fseen = 1; expSt[j] = 1; expFence = 1; expFenceWf = wA[j]; end
        else expSt[j] = 3;
        expWhy[j] = "R10";
      end else if (busyM) begin
        expSt[j] = (lA[j] == busyLine) ? 2 : 3; expWhy[j] = "R8";
      end else if (j == leadM) begin
        expSt[j] = 1; expWhy[j] = "R2"; expJoin[j] = 1; cnt++;
      end else if (lA[j] != lA[leadM]) begin
        expSt[j] = 3; expWhy[j] = "R8";
      end else if (kA[j] != kA[leadM]) begin
        expSt[j] = 2; expWhy[j] = "R4";
      end else if (lkA[j] || lkA[leadM]) begin
        expSt[j] = 2; expWhy[j] = "R5";
      end else if (rlA[j] && wA[j] != wA[leadM]) begin
        expSt[j] = 2; expWhy[j] = "R6";
      end else if (cnt >= MAXG) begin
        expSt[j] = 2; expWhy[j] = "R7";
      end else begin
        expSt[j] = 1; expWhy[j] = "R3"; expJoin[j] = 1; cnt++;
      end
    end
  endtask

  task automatic checkStatus();
    for (int j = 0; j < N; j++)
      check(reqStatus[j] == expSt[j], expWhy[j], $sformatf("lane %0d status", j), reqStatus[j], expSt[j]);
  endtask

  task automatic checkFenceAfter(input bit ef, input bit [2:0] ew);
    check(fenceAckValid == ef, "R10", "fence ack valid", fenceAckValid, ef);
    if (ef) check(fenceAckWf == ew, "R10", "fence ack wavefront", fenceAckWf, ew);
  endtask

  // One busy cycle with random traffic; caller sits at a negedge
  task automatic busyCycle(input bit [7:0] gl);
    bit ef; bit [2:0] ew;
    for (int j = 0; j < N; j++) randLane(j, gl, 8'h77);
    applyIn(); #1;
    model(1'b1, gl); checkStatus();
    ef = expFence; ew = expFenceWf;
    @(posedge clk); @(negedge clk);
    clearArr(); applyIn();
    checkFenceAfter(ef, ew);
  endtask

  task automatic runGroup();
    bit       mem[N];
    bit [1:0] mk[N]; bit [3:0] mo[N]; bit [2:0] ms[N]; bit [5:0] mi[N]; bit mn[N];
    bit [15:0] eMask; bit [127:0] eData; bit [127:0] line; bit [7:0] gl;
    bit ef; bit [2:0] ew; bit [1:0] lk; bit llk; int waits;
    applyIn(); #1;
    model(1'b0, 8'h00); checkStatus();
    ef = expFence; ew = expFenceWf;
    eMask = 0; eData = 0;
    for (int j = 0; j < N; j++) begin
      mem[j] = expJoin[j]; mk[j] = kA[j]; mo[j] = oA[j]; ms[j] = sA[j]; mi[j] = iA[j]; mn[j] = nrA[j];
      if (expJoin[j])
        for (int b = 0; b < 4; b++)
          if (b < sA[j]) begin
            eMask[oA[j] + b] = 1;
            if (kA[j] != 0) eData[(oA[j] + b)*8 +: 8] = dA[j][b*8 +: 8];
          end
    end
    gl = (leadM >= 0) ? lA[leadM] : 8'h0;
    lk = (leadM >= 0) ? kA[leadM] : 2'd0;
    llk = (leadM >= 0) ? lkA[leadM] : 1'b0;
    @(posedge clk); @(negedge clk);
    clearArr(); applyIn();
    checkFenceAfter(ef, ew);
    if (leadM < 0) begin
      check(issueValid == 0, "R2", "no issue without leader", issueValid, 0);
      return;
    end
    check(issueValid == 1, "R2", "issue valid", issueValid, 1);
    check(issueLine == gl, "R2", "issue line", issueLine, gl);
    check(issueKind == lk, "R2", "issue kind", issueKind, lk);
    check(issueLocked == llk, "R2", "issue locked", issueLocked, llk);
    check(issueMask == eMask, "R3", "issue mask", issueMask, eMask);
    check(issueData == eData, "R3", "issue data", issueData, eData);
    waits = 1 + ($urandom % 3);
    for (int w = 0; w < waits; w++) begin
      busyCycle(gl);
      check(issueValid == 0, "R2", "issue single cycle", issueValid, 0);
      check(respValid == 0, "R9", "no response before done", respValid, 0);
    end
    line = {$urandom, $urandom, $urandom, $urandom};
    dnData = line; dnDone = 1;
    @(posedge clk); @(negedge clk);
    dnDone = 0; dnData = 0;
    for (int j = 0; j < N; j++) begin
      if (mem[j]) begin
        bit hd = (mk[j] == 0) || (mk[j] == 2 && !mn[j]);
        bit [31:0] ed = 0;
        if (hd) for (int b = 0; b < 4; b++) if (b < ms[j]) ed[b*8 +: 8] = line[(mo[j] + b)*8 +: 8];
        check(respValid == 1, "R9", "response valid", respValid, 1);
        check(respId == mi[j], "R9", "response id", respId, mi[j]);
        check(respHasData == hd, "R9", "response has data", respHasData, hd);
        check(respData == ed, "R9", "response data", respData, ed);
        if ($urandom % 2 == 1) busyCycle(gl);
        else begin @(posedge clk); @(negedge clk); end
      end
    end
    check(respValid == 0, "R11", "responses finished", respValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clearArr(); applyIn(); dnDone = 0; dnData = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(issueValid == 0, "R1", "issue in reset", issueValid, 0);
    check(respValid == 0, "R1", "resp in reset", respValid, 0);
    check(fenceAckValid == 0, "R1", "fence in reset", fenceAckValid, 0);
    check(reqStatus == '0, "R1", "idle statuses", reqStatus, 0);
    @(negedge clk); rstN = 1;
    @(negedge clk);

    // R7 overflow: four compatible loads
    clearArr();
    for (int j = 0; j < N; j++) begin vA[j] = 1; lA[j] = 8'h20; oA[j] = 4'(j*4); sA[j] = 4; iA[j] = 6'(j+1); end
    runGroup();
    // R4 and R8: kind mix plus other line
    clearArr();
    vA[0] = 1; kA[0] = 0; lA[0] = 8'h21; oA[0] = 4; sA[0] = 2; iA[0] = 6'd9;
    vA[1] = 1; kA[1] = 1; lA[1] = 8'h21;
    vA[2] = 1; kA[2] = 0; lA[2] = 8'h30;
    vA[3] = 1; kA[3] = 0; lA[3] = 8'h21; oA[3] = 15; sA[3] = 1; iA[3] = 6'd10;
    runGroup();
    // R5 locked leader, then locked follower
    clearArr();
    vA[0] = 1; kA[0] = 1; lA[0] = 8'h22; lkA[0] = 1; dA[0] = 32'h11223344; sA[0] = 4;
    vA[1] = 1; kA[1] = 1; lA[1] = 8'h22; oA[1] = 8;
    runGroup();
    clearArr();
    vA[1] = 1; kA[1] = 1; lA[1] = 8'h23; dA[1] = 32'hA5; iA[1] = 3;
    vA[2] = 1; kA[2] = 1; lA[2] = 8'h23; lkA[2] = 1; oA[2] = 4;
    runGroup();
    // R6 release from other wavefront, R3 overlapping stores merge
    clearArr();
    vA[0] = 1; kA[0] = 1; lA[0] = 8'h24; wA[0] = 1; sA[0] = 4; dA[0] = 32'hDEADBEEF; iA[0] = 5;
    vA[1] = 1; kA[1] = 1; lA[1] = 8'h24; wA[1] = 2; rlA[1] = 1; oA[1] = 8;
    vA[2] = 1; kA[2] = 1; lA[2] = 8'h24; wA[2] = 1; rlA[2] = 1; oA[2] = 2; sA[2] = 2; dA[2] = 32'h0000CAFE; iA[2] = 6;
    runGroup();
    // R10 two fences with atomic group, R9 returning and non-returning atomics
    clearArr();
    vA[0] = 1; kA[0] = 3; wA[0] = 5;
    vA[1] = 1; kA[1] = 2; lA[1] = 8'h25; oA[1] = 4; sA[1] = 4; dA[1] = 32'h1; iA[1] = 7;
    vA[2] = 1; kA[2] = 3; wA[2] = 6;
    vA[3] = 1; kA[3] = 2; lA[3] = 8'h25; oA[3] = 12; sA[3] = 4; nrA[3] = 1; iA[3] = 8;
    runGroup();
    // fence alone: no issue
    clearArr(); vA[3] = 1; kA[3] = 3; wA[3] = 7;
    runGroup();

    for (int t = 0; t < 80; t++) begin
      clearArr();
      for (int j = 0; j < N; j++) randLane(j, 8'h40 + 8'(t % 3), 8'h50);
      runGroup();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule